// File: doc/BRIEF.md
# Character LCD 4-bit bus master

This block moves single bytes from a host to a parallel character-LCD controller that is wired in its narrow 4-bit bus mode. The host offers a byte together with a register-select bit, using a valid/ready handshake. The block first checks whether the controller is free by reading its status. It then sends the byte as two nibbles, each framed by an enable pulse, with the high half first.

Every status check reads two nibbles, each with its own enable pulse. The busy bit comes from the first pulse. The second pulse, which carries the low address-counter bits, is thrown away. Because the loop never stops after an odd number of pulses, the host and the controller always agree on which half comes next. This holds whatever a given controller puts on the bus during the second read while it is busy.

The time before the enable pulse, the time the enable is high and the time it is low are all set by parameters, counted in clock cycles. If the controller stays busy for a set number of status checks in a row, the block gives up on the byte and raises an error flag.

Top module: `lcd4_master`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hostReady is 1 and lcdEn, lcdDataOe, lcdRw, lcdRs and busErr are all 0.
- R2: A byte is written as two strobes with lcdRw=0, lcdRs equal to the host's hostRs bit and lcdDataOe=1 for the whole of each strobe. Byte bits 7:4 appear on lcdDataOut[3:0] in the first strobe and bits 3:0 in the second.
- R3: Each status check is two strobes with lcdRs=0, lcdRw=1 and lcdDataOe=0. The busy flag is lcdDataIn[3] (controller data line 7), sampled in the last enable-high cycle of the first strobe. The nibble read in the second strobe has no effect.
- R4: Status checks repeat until one reads busy as 0, and only then does the write start. No write strobe rises while the controller reports busy. Every status check completes both strobes, so the number of read strobes before any write is even.
- R5: Each strobe has three parts. First come SETUP_CYC cycles with lcdEn=0 and the lines set, then HIGH_CYC cycles with lcdEn=1, then LOW_CYC cycles with lcdEn=0 and the lines unchanged. The next strobe begins in the following cycle.
- R6: If POLL_LIMIT status checks in a row read busy, no write strobe is issued for that byte. The block returns to idle and busErr becomes 1 in the same cycle that hostReady returns to 1.
- R7: busErr stays 1 until the next accepted request, and it reads 0 from the cycle after that accepting edge.
- R8: hostReady is 1 only when idle. A request is taken on a clock edge with hostValid and hostReady both high, and the first setup cycle of the first status strobe follows in the next cycle. When the byte completes, hostReady returns in the cycle after the last low cycle of the second write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostValid | input | 1 | Host offers a byte |
| hostRs | input | 1 | Register select for the byte: 0 command, 1 data |
| hostData | input | 8 | Byte to write |
| hostReady | output | 1 | Block is idle and takes a request |
| busErr | output | 1 | Busy timeout seen on the last request |
| lcdRs | output | 1 | Register select line to the controller |
| lcdRw | output | 1 | Direction line: 1 read, 0 write |
| lcdEn | output | 1 | Enable strobe |
| lcdDataOut | output | 4 | Nibble driven onto data lines 7..4 |
| lcdDataOe | output | 1 | Output enable for the data drivers |
| lcdDataIn | input | 4 | Data lines 7..4 as read from the controller |

## Verification
The bench builds the full expected pin trace as soon as it sees a request accepted, and compares one entry on each falling clock edge. The first setup cycle is due one cycle after the accepting edge. Each strobe then takes SETUP_CYC+HIGH_CYC+LOW_CYC cycles, and the number of status checks follows from the busy count the bench programmed into its controller model. hostReady and busErr are due in the cycle after the last low cycle of the final strobe. A behavioural controller model rebuilds each written byte from the nibbles on the falling enable edges. It also flags any write strobe that rises while it reports busy, or after an odd number of read strobes.

// File: rtl/lcd4_pkg.sv
package lcd4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_POLL_HI, ST_POLL_LO, ST_WR_HI, ST_WR_LO
  } step_t;

  typedef enum logic [1:0] {
    PH_SET, PH_HIGH, PH_LOW
  } phase_t;

  typedef struct packed {
    logic latchReq;
    logic loadSet;
    logic loadHigh;
    logic loadLow;
    logic sampleBusy;
    logic clrPoll;
    logic incPoll;
    logic setErr;
  } ctl_t;
endpackage

// File: rtl/lcd4_dpath.sv
module lcd4_dpath
  import lcd4_pkg::*;
#(
  parameter int SETUP_CYC  = 16,
  parameter int HIGH_CYC   = 120,
  parameter int LOW_CYC    = 130,
  parameter int POLL_LIMIT = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_t       ctl,
  input  logic       lowNib,
  input  logic       reqRs,
  input  logic [7:0] reqData,
  input  logic [3:0] busIn,
  output logic       timerDone,
  output logic       busySeen,
  output logic       pollLast,
  output logic       rsHeld,
  output logic       errFlag,
  output logic [3:0] nibOut
);
  localparam int MAX_AB = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
  localparam int MAX_C  = (MAX_AB > LOW_CYC) ? MAX_AB : LOW_CYC;
  localparam int TW     = $clog2(MAX_C + 1);
  localparam int PW     = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;

  logic [TW-1:0] timer;
  logic [PW-1:0] pollCnt;
  logic [7:0]    byteReg;
  logic          unusedAcBits;

  assign unusedAcBits = ^busIn[2:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer    <= '0;
      pollCnt  <= '0;
      byteReg  <= '0;
      rsHeld   <= 1'b0;
      busySeen <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (ctl.loadSet)       timer <= TW'(SETUP_CYC - 1);
      else if (ctl.loadHigh) timer <= TW'(HIGH_CYC - 1);
      else if (ctl.loadLow)  timer <= TW'(LOW_CYC - 1);
      else if (timer != '0)  timer <= timer - 1'b1;

      if (ctl.clrPoll)      pollCnt <= '0;
      else if (ctl.incPoll) pollCnt <= pollCnt + 1'b1;

      if (ctl.latchReq) begin
        byteReg <= reqData;
        rsHeld  <= reqRs;
      end

      if (ctl.sampleBusy) busySeen <= busIn[3];

      if (ctl.latchReq)    errFlag <= 1'b0;
      else if (ctl.setErr) errFlag <= 1'b1;
    end
  end

  assign timerDone = (timer == '0);
  assign pollLast  = (pollCnt == PW'(POLL_LIMIT - 1));
  assign nibOut    = lowNib ? byteReg[3:0] : byteReg[7:4];
endmodule

// File: rtl/lcd4_ctrl.sv
module lcd4_ctrl
  import lcd4_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic hostValid,
  input  logic timerDone,
  input  logic busySeen,
  input  logic pollLast,
  input  logic rsHeld,
  output ctl_t ctl,
  output logic lowNib,
  output logic hostReady,
  output logic lcdEn,
  output logic lcdRw,
  output logic lcdRs,
  output logic lcdDataOe
);
  step_t  step, nxtStep;
  phase_t phase, nxtPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step  <= ST_IDLE;
      phase <= PH_SET;
    end else begin
      step  <= nxtStep;
      phase <= nxtPhase;
    end
  end

  always_comb begin
    ctl      = '0;
    nxtStep  = step;
    nxtPhase = phase;
    if (step == ST_IDLE) begin
      nxtPhase = PH_SET;
      if (hostValid) begin
        ctl.latchReq = 1'b1;
        ctl.clrPoll  = 1'b1;
        ctl.loadSet  = 1'b1;
        nxtStep      = ST_POLL_HI;
      end
    end else if (timerDone) begin
      case (phase)
        PH_SET: begin
          ctl.loadHigh = 1'b1;
          nxtPhase     = PH_HIGH;
        end
        PH_HIGH: begin
          ctl.sampleBusy = (step == ST_POLL_HI);
          ctl.loadLow    = 1'b1;
          nxtPhase       = PH_LOW;
        end
        default: begin
          nxtPhase    = PH_SET;
          ctl.loadSet = 1'b1;
          case (step)
            ST_POLL_HI: nxtStep = ST_POLL_LO;
            ST_POLL_LO: begin
              if (!busySeen) nxtStep = ST_WR_HI;
              else if (pollLast) begin
                ctl.setErr  = 1'b1;
                ctl.loadSet = 1'b0;
                nxtStep     = ST_IDLE;
              end else begin
                ctl.incPoll = 1'b1;
                nxtStep     = ST_POLL_HI;
              end
            end
            ST_WR_HI: nxtStep = ST_WR_LO;
            default: begin
              ctl.loadSet = 1'b0;
              nxtStep     = ST_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  assign hostReady = (step == ST_IDLE);
  assign lcdEn     = (step != ST_IDLE) && (phase == PH_HIGH);
  assign lcdRw     = (step == ST_POLL_HI) || (step == ST_POLL_LO);
  assign lcdDataOe = (step == ST_WR_HI) || (step == ST_WR_LO);
  assign lcdRs     = lcdDataOe && rsHeld;
  assign lowNib    = (step == ST_WR_LO);
endmodule

// File: rtl/lcd4_master.sv
module lcd4_master
  import lcd4_pkg::*;
#(
  parameter int SETUP_CYC  = 16,
  parameter int HIGH_CYC   = 120,
  parameter int LOW_CYC    = 130,
  parameter int POLL_LIMIT = 4096
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic       hostRs,
  input  logic [7:0] hostData,
  output logic       hostReady,
  output logic       busErr,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn,
  output logic [3:0] lcdDataOut,
  output logic       lcdDataOe,
  input  logic [3:0] lcdDataIn
);
  ctl_t ctl;
  logic timerDone, busySeen, pollLast, rsHeld, lowNib;

  lcd4_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid),
    .timerDone(timerDone), .busySeen(busySeen), .pollLast(pollLast),
    .rsHeld(rsHeld), .ctl(ctl), .lowNib(lowNib), .hostReady(hostReady),
    .lcdEn(lcdEn), .lcdRw(lcdRw), .lcdRs(lcdRs), .lcdDataOe(lcdDataOe)
  );

  lcd4_dpath #(
    .SETUP_CYC(SETUP_CYC), .HIGH_CYC(HIGH_CYC),
    .LOW_CYC(LOW_CYC), .POLL_LIMIT(POLL_LIMIT)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lowNib(lowNib),
    .reqRs(hostRs), .reqData(hostData), .busIn(lcdDataIn),
    .timerDone(timerDone), .busySeen(busySeen), .pollLast(pollLast),
    .rsHeld(rsHeld), .errFlag(busErr), .nibOut(lcdDataOut)
  );
endmodule

// File: rtl/lcd4_master_chk.sv
module lcd4_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       hostValid,
  input logic       hostReady,
  input logic       busErr,
  input logic       lcdRs,
  input logic       lcdRw,
  input logic       lcdEn,
  input logic [3:0] lcdDataOut,
  input logic       lcdDataOe
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> (!lcdEn && !lcdDataOe && !lcdRw));

  p_no_drive_on_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    lcdRw |-> (!lcdDataOe && !lcdRs));

  p_hold_through_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcdEn) |-> ($stable(lcdRs) && $stable(lcdRw) && $stable(lcdDataOe)
                      && (!lcdDataOe || $stable(lcdDataOut))));

  p_stable_while_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lcdEn && $past(lcdEn)) |-> ($stable(lcdRs) && $stable(lcdRw)
                                 && $stable(lcdDataOe) && $stable(lcdDataOut)));

  p_err_cleared_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady) |=> (!busErr && !hostReady));
endmodule

bind lcd4_master lcd4_master_chk u_chk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
  .busErr(busErr), .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdEn(lcdEn),
  .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe)
);

// File: tb/lcd4_master_test.sv
`timescale 1ns/1ps
module lcd4_master_test;
  localparam int SU = 2, HI = 3, LO = 2, LIM = 4;

  typedef struct {
    bit       en, rw, rs, oe;
    bit [3:0] d;
  } exp_t;

  logic clk = 0, rstN = 0;
  logic hostValid = 0, hostRs = 0;
  logic [7:0] hostData = 0;
  logic hostReady, busErr, lcdRs, lcdRw, lcdEn, lcdDataOe;
  logic [3:0] lcdDataOut, lcdDataIn;

  int checks = 0, errors = 0, cycles = 0;
  exp_t q[$];
  bit idleErr = 0;
  int busyLeft = 0;
  bit readPhase = 0, wPhase = 0, prevEn = 0;
  logic [3:0] hiNib;
  logic [7:0] expByte;
  bit expRs;
  int wrBytes = 0, wrExp = 0;

  always #2 clk = ~clk;

  lcd4_master #(.SETUP_CYC(SU), .HIGH_CYC(HI), .LOW_CYC(LO), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostRs(hostRs),
    .hostData(hostData), .hostReady(hostReady), .busErr(busErr),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdEn(lcdEn), .lcdDataOut(lcdDataOut),
    .lcdDataOe(lcdDataOe), .lcdDataIn(lcdDataIn)
  );

  // controller model: status {busy, ac[6:4]} then ac[3:0], ac = 7'h35
  assign lcdDataIn = readPhase ? 4'h5 : {busyLeft > 0, 3'h3};

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic pushStrobe(input bit rw, input bit rs, input bit oe, input bit [3:0] d);
    for (int i = 0; i < SU; i++) q.push_back('{0, rw, rs, oe, d});
    for (int i = 0; i < HI; i++) q.push_back('{1, rw, rs, oe, d});
    for (int i = 0; i < LO; i++) q.push_back('{0, rw, rs, oe, d});
  endtask

  // reference trace and controller model, evaluated away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit wasIdle;
      exp_t e;
      wasIdle = (q.size() == 0);
      if (wasIdle) e = '{0, 0, 0, 0, 4'h0};
      else e = q.pop_front();
      check(hostReady == wasIdle, "R8 hostReady", hostReady, wasIdle);
      check(busErr == (wasIdle && idleErr), "R6/R7 busErr", busErr, wasIdle && idleErr);
      check(lcdEn == e.en, "R5 lcdEn", lcdEn, e.en);
      check(lcdRw == e.rw && lcdRs == e.rs, "R3/R2 lcdRw,lcdRs",
            {lcdRw, lcdRs}, {e.rw, e.rs});
      check(lcdDataOe == e.oe, "R2/R3 lcdDataOe", lcdDataOe, e.oe);
      if (e.oe) check(lcdDataOut == e.d, "R2 lcdDataOut", lcdDataOut, e.d);

      // controller model edges
      if (lcdEn && !prevEn && !lcdRw) begin
        check(busyLeft == 0, "R4 write strobe while busy", busyLeft, 0);
        check(readPhase == 0, "R4 odd read strobes before write", readPhase, 0);
      end
      if (!lcdEn && prevEn) begin
        if (lcdRw) begin
          if (readPhase && busyLeft > 0) busyLeft--;
          readPhase = ~readPhase;
        end else if (!wPhase) begin
          hiNib = lcdDataOut;
          wPhase = 1;
        end else begin
          wPhase = 0;
          wrBytes++;
          check({hiNib, lcdDataOut} == expByte, "R2 byte seen by controller",
                {hiNib, lcdDataOut}, expByte);
          check(lcdRs == expRs, "R2 register select", lcdRs, expRs);
        end
      end
      prevEn = lcdEn;

      if (wasIdle && hostValid) begin
        int polls;
        bit tmo;
        tmo   = (busyLeft >= LIM);
        polls = tmo ? LIM : busyLeft + 1;
        for (int p = 0; p < polls; p++) begin
          pushStrobe(1, 0, 0, 4'h0);
          pushStrobe(1, 0, 0, 4'h0);
        end
        if (!tmo) begin
          pushStrobe(0, hostRs, 1, hostData[7:4]);
          pushStrobe(0, hostRs, 1, hostData[3:0]);
          wrExp++;
        end
        expByte = hostData;
        expRs   = hostRs;
        idleErr = tmo;
      end
    end
  end

  task automatic sendByte(input bit rs, input logic [7:0] b, input int busy);
    busyLeft = busy;
    @(posedge clk); #1;
    hostValid = 1; hostRs = rs; hostData = b;
    forever begin
      @(negedge clk);
      if (hostReady) break;
    end
    @(posedge clk); #1;
    hostValid = 0;
    @(negedge clk);
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    busyLeft = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    check(hostReady == 1 && lcdEn == 0 && lcdDataOe == 0 && busErr == 0,
          "R1 reset state", {hostReady, lcdEn, lcdDataOe, busErr}, 4'b1000);
    rstN = 1;
    @(negedge clk);
    check(hostReady == 1 && lcdRw == 0 && lcdRs == 0, "R1 first cycle after reset",
          {hostReady, lcdRw, lcdRs}, 3'b100);
    sendByte(0, 8'hA5, 0);          // R2 command write, free controller
    sendByte(1, 8'h3C, 2);          // R4 two busy polls then data write
    sendByte(1, 8'hFF, LIM - 1);    // R4 busy just under the limit
    check(wrBytes == wrExp, "R4 bytes written", wrBytes, wrExp);
    sendByte(0, 8'h81, LIM);        // R6 exact limit -> timeout
    check(busErr == 1, "R6 timeout error flag", busErr, 1);
    check(wrBytes == wrExp, "R6 no write after timeout", wrBytes, wrExp);
    repeat (5) @(negedge clk);
    check(busErr == 1, "R7 error held in idle", busErr, 1);
    sendByte(1, 8'h00, 0);          // R7 next request clears error
    check(busErr == 0, "R7 error cleared", busErr, 0);
    sendByte(0, 8'h5A, LIM + 6);    // R6 long busy
    check(busErr == 1, "R6 second timeout", busErr, 1);
    sendByte(1, 8'hC3, 1);          // R3 discard of low status nibble
    check(wrBytes == wrExp && wrExp == 5, "R2 total bytes", wrBytes, 5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule